// File: doc/BRIEF.md
# MDIO Management Master

This block is a Clause-22 station-management master. Software talks to it through a small register file with one write strobe and a combinational read-back. It frames, serializes and deserializes management transactions on a divided management clock and a tri-state data pin. Writing the write-data register sends a register write to a PHY. Raising the read bit in the command register fetches a register from a PHY. Two indicator flags let software poll for completion: busy, and a not-valid flag that guards freshly captured read data.

The register port has no flow control. Every write strobe is taken in the cycle it is presented, and reads return the addressed register in the same cycle. No stream interface exists: the only data movement is a single 16-bit word per frame, reached through registers. A launch that arrives while a frame is running is dropped, so software waits for busy to clear before the next one. The management engine can be cleared at any time through a reset bit in the configuration register.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Register map on the 3-bit select:
  - 0 is configuration: bit 15 is engine reset, [1:0] is clock select, and the reset value is 0x0003.
  - 1 is command: bit 0 requests a read.
  - 2 is address: PHY address in [12:8], register address in [4:0].
  - 3 is write data.
  - 4 is read data, which is read-only.
  - 5 is indicator: bit 0 busy, bit 1 not-valid.
  - Other selects read 0.
  - After reset every register except configuration reads 0.
- R2: A write to register 3 starts a write frame using the held address fields. The frame is sent MSB first as: 32 ones, 01, opcode 01, 5-bit PHY address, 5-bit register address, turnaround 10, then the 16 data bits.
- R3: Busy rises in the cycle after an accepted launch, well within 30 system clocks. It stays high until the MDC falling edge that ends the 64th bit.
- R4: A read frame starts only when command bit 0 goes from 0 to 1. Its opcode is 10. Writing 1 again while the bit is already 1 starts nothing.
- R5: Not-valid is set when a read starts and is cleared at the MDC rising edge that latches the last data bit. Register 4 then holds the 16 sampled bits, first-received bit in bit 15.
- R6: The output enable is low while idle and during the turnaround and data bits of a read. It is high for every other frame bit.
- R7: The data output changes only at MDC falling edges, and the input is sampled at MDC rising edges.
- R8: Engine reset takes effect at the cycle of the write that sets it. It clears busy and not-valid, forces MDC low and releases the pin. Launches are ignored while the bit is set, and operation resumes after it is cleared. Read data keeps its old value, and the reset wins over a last-bit latch in the same cycle.
- R9: Clock select 0, 1, 2, 3 gives an MDC period of 4, 10, 20, 40 system clocks. The select is taken when a frame starts.
- R10: A launch while busy is dropped, and the running frame is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read-back of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The sharpest same-cycle collision is an engine-reset write that lands on the exact system clock where the last read data bit would be latched. The bench counts MDC rising edges of a read at the fastest divider. After the 63rd edge it waits three system clocks and presents the reset write, so the write strobe coincides with the 64th rising tick. The outcome is judged at the ports: busy and not-valid must both read 0, and read data must still hold the previous read's value rather than the new word.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int DATA_W     = 16;
  localparam int SEL_W      = 3;
  localparam int FLD_W      = 5;
  localparam int DIV_CNT_W  = 5;
  localparam int CLKSEL_W   = 2;
  localparam int CFG_RST_B  = 15;
  localparam int CMD_RD_B   = 0;
  localparam int IND_BUSY_B = 0;
  localparam int IND_NV_B   = 1;
  localparam int PHY_LSB    = 8;

  typedef enum logic [SEL_W-1:0] {
    RA_CFG   = 3'd0,
    RA_CMD   = 3'd1,
    RA_ADDR  = 3'd2,
    RA_WDATA = 3'd3,
    RA_RDATA = 3'd4,
    RA_IND   = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic              rd;
    logic [FLD_W-1:0]  phy;
    logic [FLD_W-1:0]  regn;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;

  // half MDC period minus one, in system clocks
  function automatic logic [DIV_CNT_W-1:0] half_lim(logic [CLKSEL_W-1:0] sel);
    case (sel)
      2'd0:    half_lim = 5'd1;
      2'd1:    half_lim = 5'd4;
      2'd2:    half_lim = 5'd9;
      default: half_lim = 5'd19;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
  import mdio_mgmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [CLKSEL_W-1:0] sel,
  output logic                mdc,
  output logic                rise_tick,
  output logic                fall_tick
);
  logic [DIV_CNT_W-1:0] cnt_q;
  logic [CLKSEL_W-1:0]  sel_q;
  logic                 mdc_q;
  logic                 at_lim;

  assign at_lim    = (cnt_q == half_lim(sel_q));
  assign rise_tick = en && at_lim && !mdc_q;
  assign fall_tick = en && at_lim && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
      sel_q <= '1;
    end else if (!en) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
      sel_q <= sel;
    end else if (at_lim) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_mgmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [SEL_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                busy,
  input  logic                nv,
  input  logic [DATA_W-1:0]   rd_word,
  output logic [CLKSEL_W-1:0] clk_sel,
  output logic                soft_clr,
  output logic                launch,
  output mdio_req_t           req
);
  logic                rst_bit_q;
  logic [CLKSEL_W-1:0] sel_q;
  logic                cmd_rd_q;
  logic [FLD_W-1:0]    phy_q, regn_q;
  logic [DATA_W-1:0]   wdat_q;
  logic                wr_cfg, wr_cmd, wr_addr, wr_wdat;
  logic                go_wr, go_rd;

  assign wr_cfg  = reg_we && (reg_addr == RA_CFG);
  assign wr_cmd  = reg_we && (reg_addr == RA_CMD);
  assign wr_addr = reg_we && (reg_addr == RA_ADDR);
  assign wr_wdat = reg_we && (reg_addr == RA_WDATA);

  // reset is honoured already in the cycle of the setting write
  assign soft_clr = rst_bit_q || (wr_cfg && reg_wdata[CFG_RST_B]);
  assign go_wr    = wr_wdat;
  assign go_rd    = wr_cmd && reg_wdata[CMD_RD_B] && !cmd_rd_q;
  assign launch   = (go_wr || go_rd) && !soft_clr;

  assign req.rd    = go_rd;
  assign req.phy   = phy_q;
  assign req.regn  = regn_q;
  assign req.wdata = reg_wdata;
  assign clk_sel   = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_bit_q <= 1'b0;
      sel_q     <= '1;
      cmd_rd_q  <= 1'b0;
      phy_q     <= '0;
      regn_q    <= '0;
      wdat_q    <= '0;
    end else begin
      if (wr_cfg) begin
        rst_bit_q <= reg_wdata[CFG_RST_B];
        sel_q     <= reg_wdata[CLKSEL_W-1:0];
      end
      if (wr_cmd) cmd_rd_q <= reg_wdata[CMD_RD_B];
      if (wr_addr) begin
        phy_q  <= reg_wdata[PHY_LSB +: FLD_W];
        regn_q <= reg_wdata[FLD_W-1:0];
      end
      if (wr_wdat) wdat_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CFG: begin
        reg_rdata[CFG_RST_B]      = rst_bit_q;
        reg_rdata[CLKSEL_W-1:0]   = sel_q;
      end
      RA_CMD:   reg_rdata[CMD_RD_B] = cmd_rd_q;
      RA_ADDR: begin
        reg_rdata[PHY_LSB +: FLD_W] = phy_q;
        reg_rdata[FLD_W-1:0]        = regn_q;
      end
      RA_WDATA: reg_rdata = wdat_q;
      RA_RDATA: reg_rdata = rd_word;
      RA_IND: begin
        reg_rdata[IND_BUSY_B] = busy;
        reg_rdata[IND_NV_B]   = nv;
      end
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              launch,
  input  mdio_req_t         req,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              nv,
  output logic [DATA_W-1:0] rd_word,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int FRAME_LEN = PRE_LEN + 4 + 2*FLD_W + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = PRE_LEN + 4 + 2*FLD_W;
  localparam int DAT_POS   = TA_POS + 2;

  logic [FRAME_LEN-1:0] frame_q, frame_d;
  logic [IDX_W-1:0]     idx_q;
  logic                 busy_q, rd_q, nv_q;
  logic [DATA_W-1:0]    shift_q, word_q, shift_nx;
  logic                 last_bit, in_data, rd_phase;

  assign frame_d = {{PRE_LEN{1'b1}}, 2'b01,
                    (req.rd ? 2'b10 : 2'b01), req.phy, req.regn,
                    (req.rd ? 2'b11 : 2'b10),
                    (req.rd ? {DATA_W{1'b1}} : req.wdata)};
  assign last_bit = (idx_q == IDX_W'(FRAME_LEN-1));
  assign in_data  = (idx_q >= IDX_W'(DAT_POS));
  assign rd_phase = rd_q && (idx_q >= IDX_W'(TA_POS));
  assign shift_nx = {shift_q[DATA_W-2:0], mdio_i};

  assign busy    = busy_q;
  assign nv      = nv_q;
  assign rd_word = word_q;
  assign mdio_o  = frame_q[FRAME_LEN-1];
  assign mdio_oe = busy_q && !rd_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      nv_q    <= 1'b0;
      shift_q <= '0;
      word_q  <= '0;
    end else if (soft_clr) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      nv_q   <= 1'b0;
    end else if (!busy_q) begin
      if (launch) begin
        frame_q <= frame_d;
        idx_q   <= '0;
        busy_q  <= 1'b1;
        rd_q    <= req.rd;
        if (req.rd) nv_q <= 1'b1;
      end
    end else begin
      if (rise_tick && rd_q && in_data) begin
        shift_q <= shift_nx;
        if (last_bit) begin
          word_q <= shift_nx;
          nv_q   <= 1'b0;
        end
      end
      if (fall_tick) begin
        if (last_bit) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q   <= idx_q + 1'b1;
          frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic                busy, nv, soft_clr, launch;
  logic                rise_tick, fall_tick;
  logic [CLKSEL_W-1:0] clk_sel;
  logic [DATA_W-1:0]   rd_word;
  mdio_req_t           req;

  mdio_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .nv(nv),
    .rd_word(rd_word), .clk_sel(clk_sel), .soft_clr(soft_clr),
    .launch(launch), .req(req)
  );

  mdio_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .en(busy && !soft_clr), .sel(clk_sel),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .launch(launch),
    .req(req), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_i(mdio_i), .busy(busy), .nv(nv), .rd_word(rd_word),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic clk,
  input logic rst_n,
  input logic launch,
  input logic busy,
  input logic nv,
  input logic soft_clr,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  AST_BUSY_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy) |=> busy); // R3
  AST_RESET_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!busy && !nv && !mdc && !mdio_oe)); // R8
  AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy); // R6
  AST_NV_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    nv |-> busy); // R5
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R9
  AST_OUT_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o)); // R7
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .nv(nv),
  .soft_clr(soft_clr), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_drv = 1'b1;
  logic [15:0] phy_data = '0;
  logic [63:0] cap_bits = '0, cap_oe = '0;
  int          rise_cnt = 0, cyc = 0, last_rise = 0, last_per = 0;
  int          n_cmp = 0, n_mis = 0;
  bit          finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  mdio_mgmt_master u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge clk) cyc++;

  always @(posedge mdc) begin
    rise_cnt++;
    cap_bits = {cap_bits[62:0], mdio_i};
    cap_oe   = {cap_oe[62:0], mdio_oe};
    last_per = cyc - last_rise;
    last_rise = cyc;
  end

  // PHY responder: drives data bit k after the falling edge following rise 48+k
  always @(negedge mdc) begin
    if (rise_cnt >= 48 && rise_cnt < 64) phy_drv = phy_data[63-rise_cnt];
    else phy_drv = 1'b1;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    int n = 0;
    do begin rd(3'd5, v); n++; end while (v[0] && n < 20000);
  endtask

  function automatic int halfp(logic [1:0] s);
    case (s) 2'd0: return 2; 2'd1: return 5; 2'd2: return 10; default: return 20; endcase
  endfunction

  function automatic logic [63:0] exp_frame(bit r, logic [4:0] p, logic [4:0] g, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), p, g, 2'b11 ^ {1'b0, !r}, d};
  endfunction

  // {rd, sel, phy, reg, data}
  localparam logic [28:0] VEC [0:5] = '{
    {1'b0, 2'd0, 5'h01, 5'h00, 16'hA5C3},
    {1'b1, 2'd0, 5'h1F, 5'h1F, 16'h8001},
    {1'b0, 2'd1, 5'h10, 5'h0A, 16'h0000},
    {1'b1, 2'd2, 5'h00, 5'h01, 16'h7FFE},
    {1'b0, 2'd3, 5'h15, 5'h1B, 16'hFFFF},
    {1'b1, 2'd0, 5'h0A, 5'h15, 16'h3C5A}
  };

  task automatic run_frame(bit r, logic [1:0] s, logic [4:0] p, logic [4:0] g, logic [15:0] d, bit clr_cmd);
    logic [15:0] v;
    int n;
    wr(3'd0, {14'd0, s});
    wr(3'd2, {3'd0, p, 3'd0, g});
    rise_cnt = 0;
    phy_data = d;
    if (r) wr(3'd1, 16'd1); else wr(3'd3, d);
    n = 0;
    do begin rd(3'd5, v); n++; end while (!v[0] && n < 30);
    check("R3 busy within 30 clocks", {63'd0, v[0]}, 64'd1);
    if (r) check("R5 not-valid set at read start", {63'd0, v[1]}, 64'd1);
    wait_idle();
    rd(3'd5, v);
    check("R3 busy and flags clear at end", {48'd0, v}, 64'd0);
    check(r ? "R4 read frame format" : "R2 write frame format", cap_bits, exp_frame(r, p, g, r ? d : d));
    check("R6 output enable pattern", cap_oe, r ? {{46{1'b1}}, 18'd0} : {64{1'b1}});
    check("R9 MDC period", 64'(last_per), 64'(2*halfp(s)));
    if (r) begin
      rd(3'd4, v);
      check("R5 read data", {48'd0, v}, {48'd0, d});
      if (clr_cmd) wr(3'd1, 16'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state (R1)
    rd(3'd0, v); check("R1 config reset", {48'd0, v}, 64'h0003);
    for (int a = 1; a < 8; a++) begin
      rd(3'(a), v); check("R1 register reset", {48'd0, v}, 64'd0);
    end
    check("R1 idle pins", {62'd0, mdc, mdio_oe}, 64'd0);
    wr(3'd2, 16'h1F1F); rd(3'd2, v);
    check("R1 address field placement", {48'd0, v}, 64'h1F1F);

    // vector table
    for (int i = 0; i < 6; i++)
      run_frame(VEC[i][28], VEC[i][27:26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0], 1'b1);

    // R4: command bit left set, rewritten as 1, must not relaunch
    run_frame(1'b1, 2'd0, 5'h03, 5'h04, 16'h1234, 1'b0);
    rise_cnt = 0;
    wr(3'd1, 16'd1);
    repeat (50) @(negedge clk);
    rd(3'd5, v);
    check("R4 held read bit gives no new frame", {48'd0, v, 16'(rise_cnt)}, 64'd0);
    wr(3'd1, 16'd0);

    // R10: launch while busy is dropped
    wr(3'd0, 16'd0); wr(3'd2, 16'h0207);
    rise_cnt = 0;
    wr(3'd3, 16'hBEEF);
    repeat (100) @(negedge clk);
    wr(3'd3, 16'h0F0F);
    wait_idle();
    check("R10 first frame intact", cap_bits, exp_frame(1'b0, 5'h02, 5'h07, 16'hBEEF));
    repeat (100) @(negedge clk);
    check("R10 no second frame", 64'(rise_cnt), 64'd64);

    // R8: abort mid-frame, ignore launches while set, resume after clear
    rise_cnt = 0;
    wr(3'd3, 16'h5555);
    repeat (60) @(negedge clk);
    wr(3'd0, 16'h8000);
    rd(3'd5, v);
    check("R8 abort clears flags and pins", {46'd0, v, mdc, mdio_oe}, 64'd0);
    rise_cnt = 0;
    wr(3'd3, 16'h1111);
    wr(3'd1, 16'd1);
    repeat (40) @(negedge clk);
    rd(3'd5, v);
    check("R8 launch ignored during reset", {32'd0, v, 16'(rise_cnt)}, 64'd0);
    rd(3'd0, v);
    check("R8 config readback", {48'd0, v}, 64'h8000);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'd0);
    run_frame(1'b0, 2'd0, 5'h09, 5'h11, 16'hC001, 1'b1);

    // R8 collision: reset write on the tick that latches the last data bit
    run_frame(1'b1, 2'd0, 5'h04, 5'h02, 16'hAAAA, 1'b1);
    rise_cnt = 0;
    phy_data = 16'h5A5A;
    wr(3'd1, 16'd1);
    do @(negedge clk); while (rise_cnt < 63);
    repeat (3) @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h8000;
    @(negedge clk);
    reg_we = 1'b0;
    rd(3'd5, v);
    check("R8 reset wins: flags clear", {46'd0, v, mdc, mdio_oe}, 64'd0);
    rd(3'd4, v);
    check("R8 reset wins: read data kept", {48'd0, v}, 64'hAAAA);
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd0);
    run_frame(1'b1, 2'd3, 5'h11, 5'h0C, 16'h9669, 1'b1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule